// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers that a compact 16-bit instruction stream of a 32-bit processor can name. Each access carries a 4-bit logical register index. The block turns that index into a physical storage slot according to the current processor mode. Exception modes therefore see private stack-pointer and link-register copies, while the low general registers and the program counter stay common to every mode.

The block has two combinational read ports and one write port. The write port updates storage on the rising clock edge. The current status word has a dedicated port pair of its own. A saved-status port follows the mode: it reaches one of five per-exception saved words. In the two unprivileged modes it has no storage of its own behind it.

The mode used for banking comes from a separate input, not from the stored status word. Exception sequencing outside the block decides when that input changes.

Top module: `mode_banked_regfile`

## Requirements
- R1: Logical indices 0 to 7 name eight general registers whose storage is common to every mode; a value written in one mode reads back unchanged in any other mode.
- R2: Logical index 15 names a single program counter common to all modes; every write to it stores the data with bit 0 cleared.
- R3: Logical index 13 (stack pointer) and 14 (link register) each have a separate copy for each of the mode encodings FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111 and Undefined 11011.
- R4: User (10000) and System (11111) share one stack-pointer copy and one link-register copy; any mode value not listed in R3 or R4 banks exactly like User.
- R5: Each of the five exception modes of R3 has its own saved-status word, read on `spsr_q` and written through `spsr_we`/`spsr_wdata` while that mode is on `mode_i`.
- R6: In User, System or an unlisted mode, `spsr_q` shows the current status word, and a saved-status write changes no saved word.
- R7: After synchronous active-low reset every register reads zero, except the current status word, which reads 0x000000D3 (bits 7 and 6 set, bits 4:0 = 10011).
- R8: When a read port and the write port name the same physical register in one cycle, the read returns the old value; the new value appears from the next cycle on.
- R9: The current status word is a single register, written through `cpsr_we`/`cpsr_wdata` and shown on `cpsr_q` whatever the mode.
- R10: Logical indices 8 to 12 map to nothing: reads of them return zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Current processor mode encoding used for banking |
| ra_idx | input | 4 | Logical index for read port A |
| ra_data | output | DATA_W | Read port A data |
| rb_idx | input | 4 | Logical index for read port B |
| rb_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | DATA_W | Register write data |
| cpsr_we | input | 1 | Current status word write enable |
| cpsr_wdata | input | DATA_W | Current status word write data |
| cpsr_q | output | DATA_W | Current status word |
| spsr_we | input | 1 | Saved status word write enable (current mode's copy) |
| spsr_wdata | input | DATA_W | Saved status word write data |
| spsr_q | output | DATA_W | Saved status word of the current mode, or the status word in unprivileged modes |

## Verification
The bench builds the block with its default 32-bit data width, so the full reset status value and bit 0 clearing on the program counter are seen at their real positions. With six bank slots, the bench can fill every stack-pointer, link-register and saved-status copy with a distinct value and then read all of them back. That exposes any crossed bank mapping. The unlisted mode value 00000 and the unmapped indices 8 to 12 are also reachable, which covers the fallback and ignore paths.

// File: rtl/banked_rf_pkg.sv
// Package: shared encodings for the mode-banked register file.
// Assumes 5-bit mode encodings and a 4-bit logical register index.
package banked_rf_pkg;

    localparam int IDX_W  = 4;
    localparam int MODE_W = 5;

    // Logical register indices with a fixed meaning
    localparam logic [IDX_W-1:0] IDX_SP = 4'd13;
    localparam logic [IDX_W-1:0] IDX_LR = 4'd14;
    localparam logic [IDX_W-1:0] IDX_PC = 4'd15;

    // Mode encodings
    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    // Bank slot: 0 is the shared unprivileged slot, 1..5 are exception modes
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_t;

    localparam int NUM_BANKS = 6;

endpackage

// File: rtl/brf_mode_decode.sv
// Module: brf_mode_decode
// Turns a 5-bit mode encoding into a bank slot. Unknown encodings fall
// back to the unprivileged slot. Purely combinational.
module brf_mode_decode
    import banked_rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_t             bank,
    output logic              has_saved
);

    // Select the bank slot for the current mode
    always_comb begin
        case (mode)
            MODE_FIQ: bank = BANK_FIQ;
            MODE_IRQ: bank = BANK_IRQ;
            MODE_SVC: bank = BANK_SVC;
            MODE_ABT: bank = BANK_ABT;
            MODE_UND: bank = BANK_UND;
            default:  bank = BANK_USR;
        endcase
    end

    // Only exception slots own a saved-status word
    always_comb has_saved = (bank != BANK_USR);

endmodule

// File: rtl/brf_index_map.sv
// Module: brf_index_map
// Resolves a logical index plus bank slot into a physical slot number.
// Layout: low registers 0..NUM_LOW-1, then the PC, then NUM_BANKS stack
// pointers, then NUM_BANKS link registers. Indices with no register
// report hit = 0.
module brf_index_map
    import banked_rf_pkg::*;
#(
    parameter int NUM_LOW = 8,
    parameter int PHYS_W  = 5
) (
    input  logic [IDX_W-1:0]  idx,
    input  bank_t             bank,
    output logic [PHYS_W-1:0] phys,
    output logic              hit,
    output logic              is_pc
);

    localparam int PC_SLOT = NUM_LOW;
    localparam int SP_BASE = NUM_LOW + 1;
    localparam int LR_BASE = NUM_LOW + 1 + NUM_BANKS;

    // Map the logical index onto its physical slot
    always_comb begin
        phys  = '0;
        hit   = 1'b0;
        is_pc = 1'b0;
        if (int'(idx) < NUM_LOW) begin
            phys = PHYS_W'(idx);
            hit  = 1'b1;
        end else if (idx == IDX_PC) begin
            phys  = PHYS_W'(PC_SLOT);
            hit   = 1'b1;
            is_pc = 1'b1;
        end else if (idx == IDX_SP) begin
            phys = PHYS_W'(SP_BASE + int'(bank));
            hit  = 1'b1;
        end else if (idx == IDX_LR) begin
            phys = PHYS_W'(LR_BASE + int'(bank));
            hit  = 1'b1;
        end
    end

endmodule

// File: rtl/brf_storage.sv
// Module: brf_storage
// Flat array of DEPTH registers with one write and two combinational
// reads. A same-cycle read sees the value held before the edge.
// Assumes addresses below DEPTH; others read zero.
module brf_storage #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 21,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Clear on reset, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && (int'(waddr) == g)) begin
                mem[g] <= wdata;
            end
        end
    end

    // Read port A mux
    always_comb begin
        rdata_a = '0;
        for (int k = 0; k < DEPTH; k++)
            if (int'(raddr_a) == k) rdata_a = mem[k];
    end

    // Read port B mux
    always_comb begin
        rdata_b = '0;
        for (int k = 0; k < DEPTH; k++)
            if (int'(raddr_b) == k) rdata_b = mem[k];
    end

endmodule

// File: rtl/mode_banked_regfile.sv
// Module: mode_banked_regfile
// Mode-banked register file for the compact instruction state. Low
// registers and PC are shared; SP and LR are banked per exception mode;
// one status word plus five saved-status words. Banking follows mode_i,
// which the surrounding core keeps consistent with the status word.
module mode_banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               NUM_LOW    = 8,
    parameter logic [DATA_W-1:0] CPSR_RESET = DATA_W'(32'h0000_00D3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [3:0]        rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    output logic [DATA_W-1:0] cpsr_q,
    input  logic              spsr_we,
    input  logic [DATA_W-1:0] spsr_wdata,
    output logic [DATA_W-1:0] spsr_q
);

    localparam int NUM_PHYS = NUM_LOW + 1 + 2 * NUM_BANKS;
    localparam int PHYS_W   = $clog2(NUM_PHYS);

    bank_t             bank;
    logic              has_saved;
    logic [PHYS_W-1:0] pa, pb, pw;
    logic              hit_a, hit_b, hit_w;
    logic              pc_a, pc_b, pc_w;
    logic [DATA_W-1:0] val_a, val_b, wdata_eff;
    logic [DATA_W-1:0] spsr_mem [1:NUM_BANKS-1];

    brf_mode_decode u_dec (
        .mode      (mode_i),
        .bank      (bank),
        .has_saved (has_saved)
    );

    brf_index_map #(.NUM_LOW(NUM_LOW), .PHYS_W(PHYS_W)) u_map_a (
        .idx (ra_idx), .bank (bank), .phys (pa), .hit (hit_a), .is_pc (pc_a)
    );
    brf_index_map #(.NUM_LOW(NUM_LOW), .PHYS_W(PHYS_W)) u_map_b (
        .idx (rb_idx), .bank (bank), .phys (pb), .hit (hit_b), .is_pc (pc_b)
    );
    brf_index_map #(.NUM_LOW(NUM_LOW), .PHYS_W(PHYS_W)) u_map_w (
        .idx (wr_idx), .bank (bank), .phys (pw), .hit (hit_w), .is_pc (pc_w)
    );

    // Keep PC halfword aligned on every write
    always_comb wdata_eff = pc_w ? {wr_data[DATA_W-1:1], 1'b0} : wr_data;

    brf_storage #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS), .ADDR_W(PHYS_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && hit_w),
        .waddr   (pw),
        .wdata   (wdata_eff),
        .raddr_a (pa),
        .rdata_a (val_a),
        .raddr_b (pb),
        .rdata_b (val_b)
    );

    // Unmapped indices read as zero
    always_comb ra_data = hit_a ? val_a : '0;
    always_comb rb_data = hit_b ? val_b : '0;

    // Current status word: reset to supervisor with interrupts masked
    always_ff @(posedge clk) begin
        if (!rst_n)       cpsr_q <= CPSR_RESET;
        else if (cpsr_we) cpsr_q <= cpsr_wdata;
    end

    for (genvar g = 1; g < NUM_BANKS; g++) begin : g_saved
        // Saved-status word of exception slot g
        always_ff @(posedge clk) begin
            if (!rst_n)
                spsr_mem[g] <= '0;
            else if (spsr_we && has_saved && (bank == bank_t'(g)))
                spsr_mem[g] <= spsr_wdata;
        end
    end

    // Saved-status read, falling back to the status word without a bank
    always_comb begin
        spsr_q = cpsr_q;
        for (int k = 1; k < NUM_BANKS; k++)
            if (has_saved && (bank == bank_t'(k))) spsr_q = spsr_mem[k];
    end

    // Unused in logic but kept for the checker's view of port B
    logic unused_pc_flags;
    always_comb unused_pc_flags = pc_a ^ pc_b;

endmodule

// Checker: temporal properties of mode_banked_regfile, seen from its ports.
module mode_banked_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic [3:0]        ra_idx,
    input logic [DATA_W-1:0] ra_data,
    input logic [3:0]        rb_idx,
    input logic [DATA_W-1:0] rb_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cpsr_q,
    input logic [DATA_W-1:0] spsr_q
);

    // R2: the program counter never reads odd
    a_r2_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx == 4'd15) |-> (rb_data[0] == 1'b0));

    // R10: unmapped indices read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx >= 4'd8 && ra_idx <= 4'd12) |-> (ra_data == '0));

    // R6: unprivileged modes show the status word on the saved port
    a_r6_saved_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 5'b10000 || mode_i == 5'b11111) |-> (spsr_q == cpsr_q));

    // R7: first cycle out of reset shows the reset status word
    a_r7_status_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpsr_q == DATA_W'(32'h0000_00D3)));

    // R8 and R1: a low-register write is visible on port A next cycle
    a_r8_write_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < 4'd8) |=>
        ((ra_idx != $past(wr_idx)) || (ra_data == $past(wr_data))));

endmodule

bind mode_banked_regfile mode_banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .ra_idx  (ra_idx),
    .ra_data (ra_data),
    .rb_idx  (rb_idx),
    .rb_data (rb_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cpsr_q  (cpsr_q),
    .spsr_q  (spsr_q)
);

// File: tb/mode_banked_regfile_bench.sv
// Directed bench for mode_banked_regfile: one task per scenario.
module mode_banked_regfile_bench;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = M_USR;
    logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [31:0] ra_data, rb_data, wr_data = '0;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
    logic [31:0] cpsr_wdata = '0, spsr_wdata = '0, cpsr_q, spsr_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mode_banked_regfile u_mode_banked_regfile (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i),
        .ra_idx (ra_idx), .ra_data (ra_data),
        .rb_idx (rb_idx), .rb_data (rb_data),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
        .cpsr_we (cpsr_we), .cpsr_wdata (cpsr_wdata), .cpsr_q (cpsr_q),
        .spsr_we (spsr_we), .spsr_wdata (spsr_wdata), .spsr_q (spsr_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] m, input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        mode_i = m; ra_idx = idx;
        #1 d = ra_data;
    endtask

    task automatic wr_saved(input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        mode_i = m; spsr_we = 1'b1; spsr_wdata = d;
        @(negedge clk);
        spsr_we = 1'b0;
    endtask

    task automatic rd_saved(input logic [4:0] m, output logic [31:0] d);
        @(negedge clk);
        mode_i = m;
        #1 d = spsr_q;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R7 status word", cpsr_q, 32'h0000_00D3);
        for (int i = 0; i < 8; i++) begin
            rd_reg(M_USR, 4'(i), v);
            check("R7 low register", v, 32'h0);
        end
        rd_reg(M_SVC, 4'd15, v); check("R7 PC", v, 32'h0);
        rd_reg(M_SVC, 4'd13, v); check("R7 SP svc", v, 32'h0);
        rd_saved(M_SVC, v);      check("R7 saved svc", v, 32'h0);
    endtask

    task automatic t_low_shared();
        logic [31:0] v;
        wr_reg(M_FIQ, 4'd3, 32'h1111_2222);
        rd_reg(M_USR, 4'd3, v); check("R1 r3 in user", v, 32'h1111_2222);
        rd_reg(M_UND, 4'd3, v); check("R1 r3 in und", v, 32'h1111_2222);
        wr_reg(M_SYS, 4'd7, 32'hA5A5_0007);
        rd_reg(M_IRQ, 4'd7, v); check("R1 r7 in irq", v, 32'hA5A5_0007);
    endtask

    task automatic t_pc();
        wr_reg(M_IRQ, 4'd15, 32'h0000_1235);
        @(negedge clk);
        mode_i = M_USR; rb_idx = 4'd15;
        #1 check("R2 PC bit0 cleared, shared", rb_data, 32'h0000_1234);
        wr_reg(M_ABT, 4'd15, 32'hFFFF_FFFF);
        @(negedge clk);
        mode_i = M_FIQ;
        #1 check("R2 PC all ones", rb_data, 32'hFFFF_FFFE);
    endtask

    task automatic t_banked();
        logic [4:0] ml [6] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            wr_reg(ml[i], 4'd13, 32'h5000_0000 + 32'(i));
            wr_reg(ml[i], 4'd14, 32'h6000_0000 + 32'(i));
        end
        for (int i = 0; i < 6; i++) begin
            rd_reg(ml[i], 4'd13, v); check("R3 SP bank", v, 32'h5000_0000 + 32'(i));
            rd_reg(ml[i], 4'd14, v); check("R3 LR bank", v, 32'h6000_0000 + 32'(i));
        end
    endtask

    task automatic t_user_sys();
        logic [31:0] v;
        wr_reg(M_USR, 4'd13, 32'hCAFE_0013);
        rd_reg(M_SYS, 4'd13, v); check("R4 SP user->sys", v, 32'hCAFE_0013);
        wr_reg(M_SYS, 4'd14, 32'hBEEF_0014);
        rd_reg(M_USR, 4'd14, v); check("R4 LR sys->user", v, 32'hBEEF_0014);
        rd_reg(5'b00000, 4'd13, v); check("R4 unknown mode SP", v, 32'hCAFE_0013);
        rd_reg(M_FIQ, 4'd14, v); check("R4 fiq LR untouched", v, 32'h6000_0001);
    endtask

    task automatic t_saved();
        logic [4:0] ml [5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
        logic [31:0] v;
        for (int i = 0; i < 5; i++) wr_saved(ml[i], 32'h7700_0010 + 32'(i));
        for (int i = 0; i < 5; i++) begin
            rd_saved(ml[i], v); check("R5 saved per mode", v, 32'h7700_0010 + 32'(i));
        end
    endtask

    task automatic t_saved_user();
        logic [31:0] v;
        rd_saved(M_USR, v); check("R6 user saved shows status", v, cpsr_q);
        wr_saved(M_USR, 32'hDEAD_0000);
        wr_saved(M_SYS, 32'hDEAD_0001);
        wr_saved(5'b00000, 32'hDEAD_0002);
        rd_saved(M_SYS, v); check("R6 sys saved shows status", v, 32'h0000_00D3);
        for (int i = 0; i < 5; i++) begin
            logic [4:0] ml [5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
            rd_saved(ml[i], v); check("R6 exception saved untouched", v, 32'h7700_0010 + 32'(i));
        end
    endtask

    task automatic t_rdw();
        wr_reg(M_SVC, 4'd5, 32'h0000_AAAA);
        @(negedge clk);
        mode_i = M_SVC; ra_idx = 4'd5;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0000_BBBB;
        #1 check("R8 same-cycle read old", ra_data, 32'h0000_AAAA);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R8 next-cycle read new", ra_data, 32'h0000_BBBB);
    endtask

    task automatic t_status();
        @(negedge clk);
        cpsr_we = 1'b1; cpsr_wdata = 32'h2000_0010;
        @(negedge clk);
        cpsr_we = 1'b0;
        mode_i = M_FIQ;
        #1 check("R9 status in fiq", cpsr_q, 32'h2000_0010);
        @(negedge clk);
        mode_i = M_UND;
        #1 check("R9 status in und", cpsr_q, 32'h2000_0010);
        @(negedge clk);
        mode_i = M_USR;
        #1 check("R9 saved port follows new status", spsr_q, 32'h2000_0010);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        for (int i = 8; i <= 12; i++) wr_reg(M_SVC, 4'(i), 32'h9999_0000 + 32'(i));
        for (int i = 8; i <= 12; i++) begin
            rd_reg(M_SVC, 4'(i), v); check("R10 unmapped reads zero", v, 32'h0);
        end
        rd_reg(M_SVC, 4'd3, v);  check("R10 r3 unchanged", v, 32'h1111_2222);
        rd_reg(M_SVC, 4'd13, v); check("R10 SP svc unchanged", v, 32'h5000_0003);
        rd_reg(M_SVC, 4'd15, v); check("R10 PC unchanged", v, 32'hFFFF_FFFE);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_low_shared();
        t_pc();
        t_banked();
        t_user_sys();
        t_saved();
        t_saved_user();
        t_rdw();
        t_status();
        t_unmapped();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL all requirements: watchdog actual=timeout expected=done");
            summary();
        end
    end

endmodule